// File: doc/BRIEF.md
# SDRAM Read Latency Data Pipeline

This block is the output data path on the device side of a 16-bit synchronous DRAM model. The array side hands it one column word per clock on `rd_vld`, with `rd_first` on the first word of each burst. The block delays each word by the programmed read latency of 1, 2 or 3 clocks and then drives it on `dq_out`. Pad tri-state is modelled by two enables, one for each byte lane.

Two mask inputs cover the lanes: `dqm_hi` for bits 15..8 and `dqm_lo` for bits 7..0. On reads a mask bit takes effect two clocks after it is sampled. On writes it gates the lane write enables in the same cycle. A burst-stop, a precharge or an incoming write ends read output, each at its own fixed point in time. A new read burst that replaces a running one lets the words already in flight drain first.

Inputs are driven from one rising edge to the next. "Edge n" is the rising edge that samples them, and "cycle n" is the interval that follows edge n.

Top module: `dq_rdlat_pipe`

## Requirements
- R1: While `rst_n` is low, and after its release until a word is accepted, `dq_oe_hi` and `dq_oe_lo` are 0 and `dq_out` is 0.
- R2: A word accepted at edge n is driven on `dq_out` during cycle n+L-1, where L is the latency. `lat_sel` 2'd1, 2'd2 and 2'd3 give L=1, 2 and 3, and 2'd0 gives L=1.
- R3: The words of a burst, fed on consecutive edges, appear on consecutive cycles in order. A new burst (`rd_first`=1) arriving while words are in flight follows the last of them with no gap.
- R4: A read mask bit (`dqm_hi` or `dqm_lo`) sampled high at edge n clears only its own lane's enable during cycle n+1. This holds for any latency. A lane whose enable is low drives 0 on its eight `dq_out` bits.
- R5: Write masking is combinational. `wr_lane_en[1]` = `wr_vld` and not `dqm_hi`, `wr_lane_en[0]` = `wr_vld` and not `dqm_lo`, and `wr_data` equals `wr_word`.
- R6: `burst_stop` at edge n discards the word sampled at edge n, even when `rd_first` is set. It also discards later words that lack `rd_first`. Words accepted before edge n still drain.
- R7: A word is accepted only when `rd_vld` is high and either `rd_first` is high or a burst is running. A burst starts on an accepted `rd_first` word.
- R8: `precharge` at edge n ends the running burst after the word of edge n. Words driven in cycles n and n+1 are unaffected. From cycle n+2 on, no word accepted at or before edge n+1 is driven.
- R9: `wr_vld` at edge n empties the read pipeline, discards the read word of edge n and ends the running burst. Both enables are 0 in cycle n.
- R10: Both enables are 0 in every cycle in which no accepted word is due at the selected latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_sel | input | 2 | Read latency code (0 and 1 both give one clock) |
| rd_vld | input | 1 | Column word from the array is present |
| rd_first | input | 1 | Present word opens a new read burst |
| rd_word | input | 16 | Column read word |
| burst_stop | input | 1 | Ends the running read burst |
| precharge | input | 1 | Precharge issued to the open row |
| wr_vld | input | 1 | Write data on the bus this cycle |
| wr_word | input | 16 | Write data from the bus |
| dqm_hi | input | 1 | Mask for byte lane 15..8 |
| dqm_lo | input | 1 | Mask for byte lane 7..0 |
| dq_out | output | 16 | Read data driven to the pads |
| dq_oe_hi | output | 1 | Output enable, upper lane |
| dq_oe_lo | output | 1 | Output enable, lower lane |
| wr_data | output | 16 | Write data toward the array |
| wr_lane_en | output | 2 | Write enable per lane, bit 1 upper |

## Verification
Several properties are checked on every clock:
- the two-cycle read-mask blanking on each lane;
- the zero level on any disabled lane;
- the write-mask gating;
- the dead output in the cycle after a write;
- the silence from the third cycle after a precharge.

The exact latency per `lat_sel` code needs directed scenarios, and so do the order and gap-free drain when one burst replaces another. The same holds for dropping words on burst-stop and for which words survive a precharge. Only those scenarios can show that the right word is on the bus in each cycle.

// File: rtl/dq_rdlat_pipe.sv
module dq_rdlat_pipe #(
  parameter int DW      = 16,
  parameter int MAX_LAT = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(MAX_LAT+1)-1:0]   lat_sel,
  input  logic                           rd_vld,
  input  logic                           rd_first,
  input  logic [DW-1:0]                  rd_word,
  input  logic                           burst_stop,
  input  logic                           precharge,
  input  logic                           wr_vld,
  input  logic [DW-1:0]                  wr_word,
  input  logic                           dqm_hi,
  input  logic                           dqm_lo,
  output logic [DW-1:0]                  dq_out,
  output logic                           dq_oe_hi,
  output logic                           dq_oe_lo,
  output logic [DW-1:0]                  wr_data,
  output logic [1:0]                     wr_lane_en
);
  localparam int HB       = DW / 2;
  localparam int LW       = $clog2(MAX_LAT + 1);
  localparam int MASK_LAT = 2;
  localparam int PRE_OFF  = 3;

  logic [DW-1:0]      stg_d [MAX_LAT];
  logic [MAX_LAT-1:0] stg_v;
  logic               running;
  logic [MASK_LAT-1:0] mhi_sh, mlo_sh;
  logic [PRE_OFF-2:0] pc_sh;
  logic [LW-1:0]      lat_eff;
  logic               tap_v;
  logic [DW-1:0]      tap_d;

  wire flush_pc = pc_sh[PRE_OFF-2];
  wire take     = rd_vld & (rd_first | running) & ~burst_stop & ~wr_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      mhi_sh  <= '0;
      mlo_sh  <= '0;
      pc_sh   <= '0;
    end else begin
      if (wr_vld | burst_stop | precharge) running <= 1'b0;
      else if (rd_vld & rd_first)          running <= 1'b1;
      mhi_sh <= {mhi_sh[MASK_LAT-2:0], dqm_hi};
      mlo_sh <= {mlo_sh[MASK_LAT-2:0], dqm_lo};
      pc_sh  <= {pc_sh[PRE_OFF-3:0], precharge};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v <= '0;
      for (int k = 0; k < MAX_LAT; k++) stg_d[k] <= '0;
    end else begin
      stg_v[0] <= take;
      if (take) stg_d[0] <= rd_word;
      for (int k = 1; k < MAX_LAT; k++) begin
        stg_v[k] <= stg_v[k-1] & ~wr_vld & ~flush_pc;
        stg_d[k] <= stg_d[k-1];
      end
    end
  end

  always_comb begin
    lat_eff = lat_sel;
    if (lat_sel == '0)              lat_eff = LW'(1);
    else if (int'(lat_sel) > MAX_LAT) lat_eff = LW'(MAX_LAT);
    tap_v = 1'b0;
    tap_d = '0;
    for (int k = 0; k < MAX_LAT; k++) begin
      if (int'(lat_eff) == k + 1) begin
        tap_v = stg_v[k];
        tap_d = stg_d[k];
      end
    end
  end

  assign dq_oe_hi   = tap_v & ~mhi_sh[MASK_LAT-1];
  assign dq_oe_lo   = tap_v & ~mlo_sh[MASK_LAT-1];
  assign dq_out     = {dq_oe_hi ? tap_d[DW-1:HB] : {(DW-HB){1'b0}},
                       dq_oe_lo ? tap_d[HB-1:0]  : {HB{1'b0}}};
  assign wr_data    = wr_word;
  assign wr_lane_en = {wr_vld & ~dqm_hi, wr_vld & ~dqm_lo};
endmodule

// File: rtl/dq_rdlat_pipe_chk.sv
module dq_rdlat_pipe_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_vld,
  input logic          precharge,
  input logic          wr_vld,
  input logic          dqm_hi,
  input logic          dqm_lo,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe_hi,
  input logic          dq_oe_lo,
  input logic [1:0]    wr_lane_en
);
  logic [1:0] seen;
  logic [2:0] pc_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= '0;
      pc_age <= '0;
    end else begin
      if (seen != 2'd3) seen <= seen + 2'd1;
      if (precharge) pc_age <= 3'd1;
      else if (pc_age != 3'd0 && pc_age != 3'd4) pc_age <= pc_age + 3'd1;
    end
  end

  AST_RD_MASK_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2'd2 && $past(dqm_hi, 2)) |-> !dq_oe_hi);                  // R4
  AST_RD_MASK_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2'd2 && $past(dqm_lo, 2)) |-> !dq_oe_lo);                  // R4
  AST_OFF_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe_hi |-> dq_out[DW-1:DW/2] == '0);                             // R4
  AST_OFF_LO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe_lo |-> dq_out[DW/2-1:0] == '0);                              // R4
  AST_WR_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (dqm_hi || !wr_vld) |-> !wr_lane_en[1]);                            // R5
  AST_WR_MASK_GATE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (dqm_lo || !wr_vld) |-> !wr_lane_en[0]);                            // R5
  AST_WR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 2'd0 && $past(wr_vld)) |-> (!dq_oe_hi && !dq_oe_lo));      // R9
  AST_PRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_age == 3'd3 && !$past(rd_vld)) |-> (!dq_oe_hi && !dq_oe_lo));   // R8
endmodule

bind dq_rdlat_pipe dq_rdlat_pipe_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .precharge(precharge),
  .wr_vld(wr_vld), .dqm_hi(dqm_hi), .dqm_lo(dqm_lo), .dq_out(dq_out),
  .dq_oe_hi(dq_oe_hi), .dq_oe_lo(dq_oe_lo), .wr_lane_en(wr_lane_en)
);

// File: tb/dq_rdlat_pipe_tb_top.sv
`timescale 1ns/1ps
module dq_rdlat_pipe_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lat_sel = 2'd1;
  logic        rd_vld = 0, rd_first = 0, burst_stop = 0, precharge = 0, wr_vld = 0;
  logic        dqm_hi = 0, dqm_lo = 0;
  logic [15:0] rd_word = '0, wr_word = '0;
  logic [15:0] dq_out, wr_data;
  logic        dq_oe_hi, dq_oe_lo;
  logic [1:0]  wr_lane_en;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dq_rdlat_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .lat_sel(lat_sel), .rd_vld(rd_vld), .rd_first(rd_first),
    .rd_word(rd_word), .burst_stop(burst_stop), .precharge(precharge), .wr_vld(wr_vld),
    .wr_word(wr_word), .dqm_hi(dqm_hi), .dqm_lo(dqm_lo), .dq_out(dq_out),
    .dq_oe_hi(dq_oe_hi), .dq_oe_lo(dq_oe_lo), .wr_data(wr_data), .wr_lane_en(wr_lane_en)
  );

  function automatic logic [15:0] w(input int j);
    return {8'(8'h30 + j), 8'(8'hC0 + j)};
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    rd_vld = 0; rd_first = 0; burst_stop = 0; precharge = 0; wr_vld = 0;
    dqm_hi = 0; dqm_lo = 0; rd_word = '0; wr_word = '0;
  endtask

  task automatic drain();
    idle();
    repeat (5) tick();
  endtask

  task automatic chk(input string tag, input logic ehi, input logic elo, input logic [15:0] ed);
    n_chk++;
    if (dq_oe_hi !== ehi || dq_oe_lo !== elo || dq_out !== ed) begin
      n_err++;
      $display("FAIL %s: oe=%b%b dq=%h expected oe=%b%b dq=%h",
               tag, dq_oe_hi, dq_oe_lo, dq_out, ehi, elo, ed);
    end
  endtask

  task automatic chk_word(input string tag, input bit on, input int idx, input bit mh, input bit ml);
    logic ehi, elo;
    ehi = on && !mh;
    elo = on && !ml;
    chk(tag, ehi, elo, {ehi ? w(idx)[15:8] : 8'h00, elo ? w(idx)[7:0] : 8'h00});
  endtask

  task automatic t_reset();
    tick();
    chk("R1 during reset", 0, 0, 16'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", 0, 0, 16'h0);
    tick();
    chk("R10 idle", 0, 0, 16'h0);
  endtask

  task automatic t_latency(input logic [1:0] sel, input int L);
    drain();
    lat_sel = sel;
    rd_vld = 1; rd_first = 1; rd_word = w(7);
    for (int t = 0; t < 4; t++) begin
      tick();
      idle();
      chk_word($sformatf("R2 sel=%0d t=%0d", sel, t), t == L - 1, 7, 0, 0);
    end
  endtask

  task automatic t_burst_replace();
    drain();
    lat_sel = 2'd2;
    for (int t = 0; t < 9; t++) begin
      idle();
      if (t < 6) begin rd_vld = 1; rd_first = (t == 0 || t == 4); rd_word = w(t); end
      tick();
      chk_word($sformatf("R3 t=%0d", t), (t - 1 >= 0 && t - 1 <= 5), t - 1, 0, 0);
    end
  endtask

  task automatic t_rd_mask(input int L);
    drain();
    lat_sel = 2'(L);
    for (int t = 0; t < 9; t++) begin
      idle();
      if (t < 6) begin rd_vld = 1; rd_first = (t == 0); rd_word = w(t); end
      dqm_hi = (t == 2);
      dqm_lo = (t == 4);
      tick();
      chk_word($sformatf("R4 L=%0d t=%0d", L, t), (t - (L - 1) >= 0 && t - (L - 1) <= 5),
               t - (L - 1), t == 3, t == 5);
    end
  endtask

  task automatic t_wr_mask();
    drain();
    wr_vld = 1; wr_word = 16'h5AA5; dqm_hi = 1; dqm_lo = 0;
    #1;
    n_chk++;
    if (wr_lane_en !== 2'b01 || wr_data !== 16'h5AA5) begin
      n_err++;
      $display("FAIL R5 hi masked: en=%b data=%h expected en=01 data=5aa5", wr_lane_en, wr_data);
    end
    dqm_hi = 0; dqm_lo = 1;
    #1;
    n_chk++;
    if (wr_lane_en !== 2'b10) begin
      n_err++;
      $display("FAIL R5 lo masked: en=%b expected en=10", wr_lane_en);
    end
    dqm_hi = 1;
    #1;
    n_chk++;
    if (wr_lane_en !== 2'b00) begin
      n_err++;
      $display("FAIL R5 both masked: en=%b expected en=00", wr_lane_en);
    end
    dqm_hi = 0; dqm_lo = 0; wr_vld = 0;
    #1;
    n_chk++;
    if (wr_lane_en !== 2'b00) begin
      n_err++;
      $display("FAIL R5 no write: en=%b expected en=00", wr_lane_en);
    end
    idle();
    tick();
  endtask

  task automatic t_stop();
    drain();
    lat_sel = 2'd2;
    for (int t = 0; t < 7; t++) begin
      idle();
      if (t < 6) begin rd_vld = 1; rd_first = (t == 0 || t == 3); rd_word = w(t); end
      burst_stop = (t == 3);
      tick();
      chk_word($sformatf("R6 t=%0d", t), (t - 1 >= 0 && t - 1 <= 2), t - 1, 0, 0);
    end
    idle();
    rd_vld = 1; rd_word = w(9);
    tick();
    idle();
    tick();
    chk_word("R7 orphan word dropped", 0, 9, 0, 0);
  endtask

  task automatic t_precharge();
    drain();
    lat_sel = 2'd3;
    for (int t = 0; t < 8; t++) begin
      idle();
      if (t < 6) begin rd_vld = 1; rd_first = (t == 0); rd_word = w(t); end
      precharge = (t == 2);
      tick();
      chk_word($sformatf("R8 t=%0d", t), (t == 2 || t == 3), t - 2, 0, 0);
    end
  endtask

  task automatic t_wr_flush(input int L);
    drain();
    lat_sel = 2'(L);
    for (int t = 0; t < 6; t++) begin
      idle();
      if (t < 2) begin rd_vld = 1; rd_first = (t == 0); rd_word = w(t); end
      if (t == 2) begin wr_vld = 1; rd_vld = 1; rd_word = w(2); end
      if (t == 3) begin rd_vld = 1; rd_word = w(3); end
      tick();
      chk_word($sformatf("R9 L=%0d t=%0d", L, t),
               (t < 2 && t - (L - 1) >= 0 && t - (L - 1) <= 1), t - (L - 1), 0, 0);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    t_reset();
    t_latency(2'd1, 1);
    t_latency(2'd2, 2);
    t_latency(2'd3, 3);
    t_latency(2'd0, 1);
    t_burst_replace();
    t_rd_mask(1);
    t_rd_mask(3);
    t_wr_mask();
    t_stop();
    t_precharge();
    t_wr_flush(1);
    t_wr_flush(3);
    drain();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule